// File: doc/BRIEF.md
# User-Mode Dummy Byte Inserter

This block sits between a flash controller's user-mode write path and its SPI byte stream. Software in user mode writes the bytes of a flash transaction by hand: an opcode, an address, then the dummy phase and the data. The block snoops that stream from the moment chip select goes active. It decodes the first byte as a flash opcode and counts the bytes that follow. For opcodes that need dummy cycles, it replaces whatever software writes in the dummy phase with a burst of generated bytes, each carrying a programmable dummy value.

Each accepted bus write carries one to four bytes, and those bytes leave least significant byte first, one per clock, on the SPI byte interface. A ready signal holds off the next bus write until the current write or the dummy burst has fully left. Once a dummy burst has been issued, or the opcode needs no dummies, snooping stops and every later write passes through untouched until chip select goes active again.

Top module: `dbi_top`

## Requirements
- R1: After reset no SPI byte is presented, `wr_ready` is high and snooping is off, so a write passes through unchanged.
- R2: A passed-through write of N bytes (1 to 4) appears on `spi_valid`/`spi_byte` as N bytes on consecutive cycles, bit 7:0 of `wr_data` first, starting the cycle after the write is accepted.
- R3: A low-to-high change of `cs_active` arms snooping with the byte index at zero, and bit 7:0 of the next accepted write is taken as the opcode. That write is still forwarded.
- R4: Opcodes 0x03, 0x02, 0xA2, 0x32, 0x13, 0x12, 0x34 and any opcode not listed in R5 to R7 turn snooping off, and all later writes pass through.
- R5: Opcodes 0x0B, 0x3B, 0x6B, 0x3C, 0x6C request 8 dummy bytes.
- R6: Opcodes 0xBB, 0x0C, 0xBC request 16 dummy bytes.
- R7: Opcodes 0xEB, 0xEC request 32 dummy bytes.
- R8: While snooping, each forwarded write advances the byte index by its size. The dummy phase is reached when the index is at least the address width plus one, where the address width is 3 when `addr4` is low and 4 when it is high.
- R9: A write accepted in the dummy phase is discarded. In its place the requested number of bytes, each equal to `dummy_val`, is emitted on consecutive cycles, and snooping then turns off.
- R10: `wr_ready` is low exactly while bytes are being emitted, and it returns high the cycle after the last byte.
- R11: While `cs_active` is low, snooping is off, so a transaction abandoned before its dummy phase produces no dummy bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | Chip select of the selected flash is active |
| addr4 | input | 1 | 4-byte address mode |
| dummy_val | input | 8 | Value placed in every generated dummy byte |
| wr_valid | input | 1 | User-mode bus write request |
| wr_data | input | 32 | Write data, byte 0 in bits 7:0 |
| wr_size | input | 3 | Number of valid bytes in the write, 1 to 4 |
| wr_ready | output | 1 | Write is accepted when both valid and ready are high |
| spi_valid | output | 1 | A byte is presented on the SPI interface this cycle |
| spi_byte | output | 8 | SPI byte |

## Verification
The hardest situation to reach is the exact boundary where the byte index crosses into the dummy phase. Writes of mixed sizes can jump over the threshold instead of landing on it, and the threshold moves with `addr4`. The stimulus covers this by sending opcode and address as one 4-byte write, as single bytes, and as 2-byte pieces that overshoot the threshold, in both address modes. It also drops chip select midway through an address to show that a half-finished transaction never yields a burst.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    typedef enum logic [1:0] {
        EMIT_IDLE = 2'd0,
        EMIT_DATA = 2'd1,
        EMIT_FILL = 2'd2
    } emit_mode_e;
endpackage

// File: rtl/dbi_opcode_lut.sv
module dbi_opcode_lut #(
    parameter int UNIT_W = 3
) (
    input  logic [7:0]        opcode,
    output logic [UNIT_W-1:0] units
);
    always_comb begin
        case (opcode)
            8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: units = UNIT_W'(1);
            8'hBB, 8'h0C, 8'hBC:               units = UNIT_W'(2);
            8'hEB, 8'hEC:                      units = UNIT_W'(4);
            default:                           units = '0;
        endcase
    end
endmodule

// File: rtl/dbi_snoop.sv
module dbi_snoop #(
    parameter int SZ_W           = 3,
    parameter int IDX_W          = 4,
    parameter int CNT_W          = 6,
    parameter int UNIT_W         = 3,
    parameter int DUMMY_PER_UNIT = 8,
    parameter int ADDR_SHORT     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              addr4,
    input  logic              accept,
    input  logic [SZ_W-1:0]   wr_size,
    input  logic [UNIT_W-1:0] units,
    output logic              fwd,
    output logic              fill,
    output logic [CNT_W-1:0]  fill_cnt
);
    localparam logic [CNT_W-1:0] PER_UNIT  = CNT_W'(DUMMY_PER_UNIT);
    localparam logic [IDX_W-1:0] PHASE_S   = IDX_W'(ADDR_SHORT + 1);
    localparam logic [IDX_W-1:0] PHASE_L   = IDX_W'(ADDR_SHORT + 2);

    typedef struct packed {
        logic             on;
        logic             cs;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] pend;
    } snoop_t;

    snoop_t st_d, st_q;
    logic [IDX_W-1:0] phase_at;

    always_comb begin
        st_d     = st_q;
        st_d.cs  = cs_active;
        fwd      = 1'b0;
        fill     = 1'b0;
        phase_at = addr4 ? PHASE_L : PHASE_S;
        if (accept) begin
            if (!st_q.on) begin
                fwd = 1'b1;
            end else if (st_q.idx == '0) begin
                fwd = 1'b1;
                if (units == '0) begin
                    st_d.on = 1'b0;
                end else begin
                    st_d.pend = CNT_W'(units) * PER_UNIT;
                    st_d.idx  = st_q.idx + IDX_W'(wr_size);
                end
            end else if (st_q.idx >= phase_at) begin
                fill    = 1'b1;
                st_d.on = 1'b0;
            end else begin
                fwd      = 1'b1;
                st_d.idx = st_q.idx + IDX_W'(wr_size);
            end
        end
        if (cs_active && !st_q.cs) begin
            st_d.on  = 1'b1;
            st_d.idx = '0;
        end else if (!cs_active) begin
            st_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fill_cnt = st_q.pend;

    AST_CS_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !st_q.on); // R11
    AST_CS_RISE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && !st_q.cs) |=> (st_q.on && st_q.idx == '0)); // R3
    AST_FILL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> fill_cnt != '0); // R9
endmodule

// File: rtl/dbi_emitter.sv
module dbi_emitter
    import dbi_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int SZ_W  = 3,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_data,
    input  logic             load_fill,
    input  logic [BUS_W-1:0] data,
    input  logic [SZ_W-1:0]  size,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic [7:0]       fill_byte,
    output logic             busy,
    output logic             spi_valid,
    output logic [7:0]       spi_byte
);
    typedef struct packed {
        emit_mode_e       mode;
        logic [BUS_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       fill;
    } emit_t;

    emit_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_data) begin
            st_d.sh   = data;
            st_d.cnt  = CNT_W'(size);
            st_d.mode = (size == '0) ? EMIT_IDLE : EMIT_DATA;
        end else if (load_fill) begin
            st_d.cnt  = fill_cnt;
            st_d.fill = fill_byte;
            st_d.mode = EMIT_FILL;
        end else if (st_q.mode != EMIT_IDLE) begin
            st_d.sh  = st_q.sh >> 8;
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.mode = EMIT_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.mode != EMIT_IDLE);
    assign spi_valid = busy;
    assign spi_byte  = (st_q.mode == EMIT_FILL) ? st_q.fill : st_q.sh[7:0];

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_data || load_fill) |-> !busy); // R10
    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_data && load_fill)); // R9
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> st_q.cnt == $past(st_q.cnt) - 1'b1); // R10
    AST_FILL_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load_fill |=> (spi_valid && spi_byte == $past(fill_byte))); // R9
endmodule

// File: rtl/dbi_top.sv
module dbi_top #(
    parameter int BUS_BYTES      = 4,
    parameter int DUMMY_PER_UNIT = 8,
    parameter int MAX_UNITS      = 4,
    parameter int ADDR_SHORT     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_active,
    input  logic                   addr4,
    input  logic [7:0]             dummy_val,
    input  logic                   wr_valid,
    input  logic [BUS_BYTES*8-1:0] wr_data,
    input  logic [$clog2(BUS_BYTES+1)-1:0] wr_size,
    output logic                   wr_ready,
    output logic                   spi_valid,
    output logic [7:0]             spi_byte
);
    localparam int BUS_W  = BUS_BYTES * 8;
    localparam int SZ_W   = $clog2(BUS_BYTES + 1);
    localparam int UNIT_W = $clog2(MAX_UNITS + 1);
    localparam int CNT_W  = $clog2(MAX_UNITS * DUMMY_PER_UNIT + 1);
    localparam int IDX_W  = $clog2(ADDR_SHORT + 2 + 2 * BUS_BYTES);

    logic              busy;
    logic              accept;
    logic              fwd;
    logic              fill;
    logic [CNT_W-1:0]  fill_cnt;
    logic [UNIT_W-1:0] units;

    assign wr_ready = !busy;
    assign accept   = wr_valid && wr_ready;

    dbi_opcode_lut #(.UNIT_W(UNIT_W)) u_lut (
        .opcode (wr_data[7:0]),
        .units  (units)
    );

    dbi_snoop #(
        .SZ_W           (SZ_W),
        .IDX_W          (IDX_W),
        .CNT_W          (CNT_W),
        .UNIT_W         (UNIT_W),
        .DUMMY_PER_UNIT (DUMMY_PER_UNIT),
        .ADDR_SHORT     (ADDR_SHORT)
    ) u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .addr4     (addr4),
        .accept    (accept),
        .wr_size   (wr_size),
        .units     (units),
        .fwd       (fwd),
        .fill      (fill),
        .fill_cnt  (fill_cnt)
    );

    dbi_emitter #(
        .BUS_W (BUS_W),
        .SZ_W  (SZ_W),
        .CNT_W (CNT_W)
    ) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_data (fwd),
        .load_fill (fill),
        .data      (wr_data),
        .size      (wr_size),
        .fill_cnt  (fill_cnt),
        .fill_byte (dummy_val),
        .busy      (busy),
        .spi_valid (spi_valid),
        .spi_byte  (spi_byte)
    );

    AST_NO_OUTPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_valid); // R10
    AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_size != '0) |=> spi_valid); // R2
endmodule

// File: tb/dbi_top_tb.sv
module dbi_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_active = 1'b0;
    logic        addr4 = 1'b0;
    logic [7:0]  dummy_val = 8'h00;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  wr_size = 3'd1;
    logic        wr_ready;
    logic        spi_valid;
    logic [7:0]  spi_byte;

    int tests = 0;
    int fails = 0;
    int ready_err = 0;
    bit finished = 1'b0;
    logic [7:0] got[$];
    logic [7:0] exp[$];

    always #2 clk = ~clk;

    dbi_top u_dut (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .addr4(addr4),
        .dummy_val(dummy_val), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_size(wr_size), .wr_ready(wr_ready), .spi_valid(spi_valid),
        .spi_byte(spi_byte)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_valid) got.push_back(spi_byte);
            if (wr_ready == spi_valid) ready_err++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic check_stream(input string tag);
        bit ok = (got.size() == exp.size());
        int bad = -1;
        if (ok) begin
            for (int i = 0; i < exp.size(); i++) begin
                if (got[i] !== exp[i] && bad < 0) bad = i;
            end
            ok = (bad < 0);
        end
        if (!ok && bad >= 0)
            chk(ok, tag, $sformatf("byte %0d actual %02h expected %02h", bad, got[bad], exp[bad]));
        else
            chk(ok, tag, $sformatf("stream length actual %0d expected %0d", got.size(), exp.size()));
        got.delete();
        exp.delete();
    endtask

    task automatic bus_wr(input logic [31:0] d, input int sz);
        do @(negedge clk); while (!wr_ready);
        wr_data  = d;
        wr_size  = 3'(sz);
        wr_valid = 1'b1;
        @(posedge clk);
        #1 wr_valid = 1'b0;
        do @(negedge clk); while (!wr_ready);
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_active = v;
        @(negedge clk);
    endtask

    task automatic push_fill(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) exp.push_back(v);
    endtask

    // R1, R2: reset state and plain pass-through
    task automatic t_reset_pass();
        @(negedge clk);
        chk(spi_valid == 1'b0, "R1", $sformatf("spi_valid actual %0b expected 0", spi_valid));
        chk(wr_ready == 1'b1, "R1", $sformatf("wr_ready actual %0b expected 1", wr_ready));
        bus_wr(32'hAABBCCDD, 4);
        exp = '{8'hDD, 8'hCC, 8'hBB, 8'hAA};
        check_stream("R1");
        bus_wr(32'h00001234, 2);
        exp = '{8'h34, 8'h12};
        check_stream("R2");
    endtask

    // R3, R5, R8, R9: one-unit opcode, byte-wise address, 3-byte mode
    task automatic t_fast_read();
        addr4 = 1'b0; dummy_val = 8'hA5;
        set_cs(1'b1);
        bus_wr(32'h0B, 1);
        bus_wr(32'h11, 1);
        bus_wr(32'h22, 1);
        bus_wr(32'h33, 1);
        exp = '{8'h0B, 8'h11, 8'h22, 8'h33};
        check_stream("R3");
        bus_wr(32'h5A, 1);
        push_fill(8'hA5, 8);
        check_stream("R5");
        bus_wr(32'h77, 1);
        exp = '{8'h77};
        check_stream("R9");
        set_cs(1'b0);
    endtask

    // R6, R8: two-unit opcode in 4-byte mode, packed opcode+address
    task automatic t_dual_io_4b();
        addr4 = 1'b1; dummy_val = 8'h3C;
        set_cs(1'b1);
        bus_wr(32'h030201BB, 4);
        bus_wr(32'h04, 1);
        exp = '{8'hBB, 8'h01, 8'h02, 8'h03, 8'h04};
        check_stream("R8");
        bus_wr(32'hFFFF, 2);
        push_fill(8'h3C, 16);
        check_stream("R6");
        set_cs(1'b0);
    endtask

    // R8: in 4-byte mode a packed 4-byte write alone does not reach the phase
    task automatic t_mode_threshold();
        addr4 = 1'b0; dummy_val = 8'h5E;
        set_cs(1'b1);
        bus_wr(32'h030201EB, 4);
        exp = '{8'hEB, 8'h01, 8'h02, 8'h03};
        check_stream("R8");
        bus_wr(32'hDEADBEEF, 4);
        push_fill(8'h5E, 32);
        check_stream("R7");
        set_cs(1'b0);
        addr4 = 1'b1; dummy_val = 8'h66;
        set_cs(1'b1);
        bus_wr(32'h030201EC, 4);
        bus_wr(32'h99, 1);
        exp = '{8'hEC, 8'h01, 8'h02, 8'h03, 8'h99};
        check_stream("R8");
        bus_wr(32'h88, 1);
        push_fill(8'h66, 32);
        check_stream("R7");
        set_cs(1'b0);
    endtask

    // R4: no-dummy and unknown opcodes never insert
    task automatic t_no_dummy();
        addr4 = 1'b0; dummy_val = 8'hC3;
        set_cs(1'b1);
        bus_wr(32'h03, 1);
        bus_wr(32'h00030201, 3);
        bus_wr(32'h44, 1);
        bus_wr(32'h55, 1);
        exp = '{8'h03, 8'h01, 8'h02, 8'h03, 8'h44, 8'h55};
        check_stream("R4");
        set_cs(1'b0);
        set_cs(1'b1);
        bus_wr(32'h9F, 1);
        bus_wr(32'h0B0B0B0B, 4);
        bus_wr(32'h12, 1);
        exp = '{8'h9F, 8'h0B, 8'h0B, 8'h0B, 8'h0B, 8'h12};
        check_stream("R4");
        set_cs(1'b0);
    endtask

    // R11: chip select dropped mid-address cancels the burst
    task automatic t_abort();
        addr4 = 1'b0; dummy_val = 8'h81;
        set_cs(1'b1);
        bus_wr(32'h6B, 1);
        bus_wr(32'h01, 1);
        set_cs(1'b0);
        bus_wr(32'h02, 1);
        bus_wr(32'h03, 1);
        bus_wr(32'h04, 1);
        bus_wr(32'h05, 1);
        exp = '{8'h6B, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
        check_stream("R11");
    endtask

    // R8: 2-byte writes overshoot the threshold
    task automatic t_overshoot();
        addr4 = 1'b0; dummy_val = 8'h42;
        set_cs(1'b1);
        bus_wr(32'h3B, 1);
        bus_wr(32'h0201, 2);
        bus_wr(32'h0403, 2);
        exp = '{8'h3B, 8'h01, 8'h02, 8'h03, 8'h04};
        check_stream("R8");
        bus_wr(32'h0605, 2);
        push_fill(8'h42, 8);
        check_stream("R5");
        set_cs(1'b0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_pass();
        t_fast_read();
        t_dual_io_4b();
        t_mode_threshold();
        t_no_dummy();
        t_abort();
        t_overshoot();
        chk(ready_err == 0, "R10", $sformatf("ready/valid overlap cycles actual %0d expected 0", ready_err));
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule